// File: doc/BRIEF.md
# Masked Interrupt Flag and Enable Controller

This block collects pending events from several sources (two timers, a shift register and further peripheral sources) into a 7-bit flag register and gates them with a 7-bit enable register. It produces one active-high interrupt request. The request is high whenever at least one flag that is pending is also enabled. Event pulses from the surrounding logic set flag bits. The host clears flags in two ways: by writing ones to the flag register, or through per-bit clear strobes that the peripheral raises as a side effect of data reads. For example, a read of the shift data clears the shift flag.

The enable register is not written directly. Bit 7 of the written byte selects the mode. When bit 7 is 1, every enable marked by a 1 in bits 6:0 is set. When bit 7 is 0, every marked enable is cleared. Either way, unmarked bits keep their value. Reads return both registers as 8-bit values. Bit 7 of the flag view summarises "an enabled interrupt is pending", and bit 7 of the enable view is always 1. Address decode and the event generators are outside the block; it sees only a register select, a write strobe with data, and a read select.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq` is registered. It is high in the cycle after a clock edge at which the AND of flags and enables was nonzero, and low otherwise.
- R2: With `rd_sel`=0 (flag view), `rd_data[6:0]` shows the flags, and `rd_data[7]` is 1 exactly when any flag is both pending and enabled.
- R3: With `rd_sel`=1 (enable view), `rd_data[6:0]` shows the enables and `rd_data[7]` is always 1.
- R4: A write with `wr_sel`=1 and `wr_data[7]`=1 sets each enable whose bit in `wr_data[6:0]` is 1 and leaves the other enables unchanged.
- R5: A write with `wr_sel`=1 and `wr_data[7]`=0 clears each enable whose bit in `wr_data[6:0]` is 1 and leaves the other enables unchanged.
- R6: A write with `wr_sel`=0 clears each flag whose bit in `wr_data[6:0]` is 1. Other flags are unchanged, `wr_data[7]` has no effect, and the enables are untouched.
- R7: A 1 on `evt_set[i]` sets flag i. A 1 on `rd_clear[i]` clears flag i. Timer 1 uses bit 6, timer 2 uses bit 5 and the shift register uses bit 2, so the strobe from a shift data read is `rd_clear[2]`.
- R8: When a set and a clear (by write or by strobe) hit the same flag at the same edge, the flag ends up set.
- R9: While `rst` is high at a clock edge, flags and enables become 0 and `irq` becomes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 7 | Per-source event pulses that set flags |
| rd_clear | input | 7 | Per-source clear strobes from read side effects |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 flag register, 1 enable register |
| wr_data | input | 8 | Host write data |
| rd_sel | input | 1 | Read view: 0 flag register, 1 enable register |
| rd_data | output | 8 | Selected register view with its status bit 7 |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
Every one of the 128 enable patterns is loaded through a clear-all write followed by a set-mode write. Against each pattern, every one of the 128 flag patterns is raised by event pulses and then removed by a flag write that also has bit 7 set. Together these sweeps separate flags from enables, check the summary bit and the request for every overlap, and show that the request lags the flags by one edge. Selective clear-mode writes with alternating masks show that unmarked enables are kept. Directed cycles put a set on the same bit as a write clear or a strobe clear, and use the timer and shift bit positions, to expose any priority or mapping error.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    // Register view / write target select
    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // Fixed source positions that neighbouring logic decodes
    localparam int unsigned SRC_TIMER1 = 6;
    localparam int unsigned SRC_TIMER2 = 5;
    localparam int unsigned SRC_SHIFT  = 2;

    // Decoded host write, one per target register
    typedef struct packed {
        logic       flag_clr;   // write to flag register
        logic       en_upd;     // write to enable register
        logic       en_set;     // 1: set marked enables, 0: clear them
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic valid,
                                             input reg_sel_e sel,
                                             input logic mode_bit);
        wr_dec_t d;
        d.flag_clr = valid && (sel == SEL_FLAGS);
        d.en_upd   = valid && (sel == SEL_ENABLE);
        d.en_set   = mode_bit;
        return d;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] rd_clear,
    input  logic            wr_clr,
    input  logic [NSRC-1:0] wr_mask,
    output logic [NSRC-1:0] flag_q
);
    logic [NSRC-1:0] wr_kill;

    assign wr_kill = wr_clr ? wr_mask : '0;

    // One cell per source; a set always beats a clear in the same cycle
    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (evt_set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (wr_kill[i] || rd_clear[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic            set_mode,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] en_q
);
    logic [NSRC-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (upd) begin
            en_d = set_mode ? (en_q | mask) : (en_q & ~mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/irq_request_gen.sv
module irq_request_gen #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] flag_q,
    input  logic [NSRC-1:0] en_q,
    output logic            pending,
    output logic            irq_q
);
    assign pending = |(flag_q & en_q);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pending;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] rd_clear,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [NSRC:0]   wr_data,
    input  logic            rd_sel,
    output logic [NSRC:0]   rd_data,
    output logic            irq
);
    localparam int unsigned MODE_BIT = NSRC;

    wr_dec_t         wdec;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            pending;

    assign wdec = decode_write(wr_en, reg_sel_e'(wr_sel), wr_data[MODE_BIT]);

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt_set  (evt_set),
        .rd_clear (rd_clear),
        .wr_clr   (wdec.flag_clr),
        .wr_mask  (wr_data[NSRC-1:0]),
        .flag_q   (flag_q)
    );

    irq_enable_bank #(.NSRC(NSRC)) u_enables (
        .clk      (clk),
        .rst      (rst),
        .upd      (wdec.en_upd),
        .set_mode (wdec.en_set),
        .mask     (wr_data[NSRC-1:0]),
        .en_q     (en_q)
    );

    irq_request_gen #(.NSRC(NSRC)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flag_q  (flag_q),
        .en_q    (en_q),
        .pending (pending),
        .irq_q   (irq)
    );

    always_comb begin
        if (reg_sel_e'(rd_sel) == SEL_ENABLE) rd_data = {1'b1, en_q};
        else                                  rd_data = {pending, flag_q};
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int unsigned NSRC = 7
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] evt_set,
    input logic            wr_en,
    input logic            wr_sel,
    input logic [NSRC:0]   wr_data,
    input logic            rd_sel,
    input logic [NSRC:0]   rd_data,
    input logic            irq,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] en_q
);
    assert_irq_high_R1: assert property (@(posedge clk) disable iff (rst)
        (|(flag_q & en_q)) |=> irq);

    assert_irq_low_R1: assert property (@(posedge clk) disable iff (rst)
        !(|(flag_q & en_q)) |=> !irq);

    assert_enable_view_R3: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> rd_data[NSRC]);

    assert_enable_set_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data[NSRC]) |=>
        ((en_q & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

    assert_enable_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !wr_data[NSRC]) |=>
        ((en_q & $past(wr_data[NSRC-1:0])) == '0));

    assert_flag_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=>
        ((flag_q & $past(wr_data[NSRC-1:0]) & ~$past(evt_set)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((flag_q & $past(evt_set)) == $past(evt_set)));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && en_q == '0 && !irq));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_set),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .irq     (irq),
    .flag_q  (flag_q),
    .en_q    (en_q)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] evt_set;
    logic [6:0] rd_clear;
    logic       wr_en;
    logic       wr_sel;
    logic [7:0] wr_data;
    logic       rd_sel;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [6:0] m_flag = '0;
    logic [6:0] m_en   = '0;
    logic       m_irq  = 1'b0;

    always #2 clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk(clk), .rst(rst), .evt_set(evt_set), .rd_clear(rd_clear),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model after rising edge
    task automatic cyc(input logic [6:0] evt, input logic [6:0] clr,
                       input logic we, input logic sel, input logic [7:0] d);
        @(negedge clk);
        evt_set = evt; rd_clear = clr; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        m_irq  = |(m_flag & m_en);
        m_flag = (m_flag & ~((we && !sel) ? d[6:0] : 7'h00) & ~clr) | evt;
        if (we && sel) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        evt_set = '0; rd_clear = '0; wr_en = 1'b0;
    endtask

    task automatic idle();
        cyc(7'h00, 7'h00, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic look_flags(input string req);
        rd_sel = 1'b0; #1;
        check(req, rd_data, {|(m_flag & m_en), m_flag});
    endtask

    task automatic look_en(input string req);
        rd_sel = 1'b1; #1;
        check(req, rd_data, {1'b1, m_en});
    endtask

    task automatic look_irq(input string req);
        check(req, {7'h00, irq}, {7'h00, m_irq});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; evt_set = '0; rd_clear = '0; wr_en = 0; wr_sel = 0;
        wr_data = '0; rd_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R9: reset state
        look_flags("R9 flags after reset");
        look_en("R9 enables after reset");
        look_irq("R9 irq after reset");

        // Exhaustive enable x flag sweep
        for (int e = 0; e < 128; e++) begin
            cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'h7F);
            cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'h80 | 8'(e));
            look_en("R3 R4 enable set sweep");
            for (int f = 0; f < 128; f++) begin
                cyc(7'(f), 7'h00, 1'b0, 1'b0, 8'h00);
                look_irq("R1 irq lags flag set by one edge");
                look_flags("R2 R7 flag view after events");
                idle();
                look_irq("R1 irq after flags settle");
                cyc(7'h00, 7'h00, 1'b1, 1'b0, 8'h80 | 8'(f));
                look_flags("R6 flag write clears with bit7 ignored");
                look_en("R6 flag write leaves enables");
            end
        end

        // R5: selective clear leaves unmarked enables
        cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'hFF);
        cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'h55);
        look_en("R5 clear marked enables 0x55");
        cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'h0A);
        look_en("R5 clear marked enables 0x0A");

        // R6: partial flag clear keeps other flags
        cyc(7'h7F, 7'h00, 1'b0, 1'b0, 8'h00);
        cyc(7'h00, 7'h00, 1'b1, 1'b0, 8'h33);
        look_flags("R6 partial flag clear");

        // R7: timer and shift positions, read-clear strobes
        cyc(7'h00, 7'h00, 1'b1, 1'b0, 8'h7F);
        cyc(7'h64, 7'h00, 1'b0, 1'b0, 8'h00);
        look_flags("R7 timer1 timer2 shift flags set");
        cyc(7'h00, 7'h04, 1'b0, 1'b0, 8'h00);
        look_flags("R7 shift data read clears bit 2");
        check("R7 shift flag clear", {7'h00, rd_data[2]}, 8'h00);
        cyc(7'h00, 7'h40, 1'b0, 1'b0, 8'h00);
        look_flags("R7 timer1 strobe clears bit 6");

        // R8: set beats simultaneous clears
        cyc(7'h04, 7'h04, 1'b0, 1'b0, 8'h00);
        look_flags("R8 set beats strobe clear");
        cyc(7'h20, 7'h00, 1'b1, 1'b0, 8'h20);
        look_flags("R8 set beats write clear");
        check("R8 timer2 bit kept", {7'h00, rd_data[5]}, 8'h01);

        // R9: reset mid-run
        cyc(7'h00, 7'h00, 1'b1, 1'b1, 8'hFF);
        idle();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; m_flag = '0; m_en = '0; m_irq = 1'b0;
        @(negedge clk); rst = 1'b0;
        look_flags("R9 flags cleared by reset");
        look_en("R9 enables cleared by reset");
        look_irq("R9 irq cleared by reset");

        finish_run();
    end
endmodule